// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the decision engine at the home node of a directory-based cache-coherence scheme. It works on one memory line per message. The caller presents three things: an incoming coherence message, the node that sent it, and the line's current directory entry. The entry holds a state, an owner node and a sharer bit-vector with one bit per node. The block answers with the rewritten entry and with up to two outgoing message records.

The controller never queues a request or waits for one. A conflict with an owning cache sends the line into a transient busy state, and the requestor gets a speculative data reply in the same step. A request that arrives while the line is busy is refused with a NAK. A writeback that crosses an intervention in flight is bounced to the new owner.

If the request network cannot take an intervention or invalidation when a message is accepted, the block sends a backoff record on the reply channel instead. The backoff carries the target node or the sharer list, so the requestor can issue those messages itself. A poisoned line answers processor accesses with a bus error. A message that makes no sense for the current state raises a protocol-error pulse and changes nothing.

Top module: `dir_home_ctrl`

## Requirements
- R1: After a synchronous active-low reset, in_ready is 1 and out_valid, wr_valid and perr are 0.
- R2: A read (in_kind 0) or read-exclusive (1) that finds the line Unowned (state 0), or Exclusive (2) owned by the sender, writes Exclusive with owner = sender and an empty sharer vector. It emits one exclusive reply (kind 0) to the sender.
- R3: A read in Shared (1) sets the sender's bit in the sharer vector, leaves the state and owner unchanged, and emits one shared reply (kind 1) to the sender.
- R4: A read in Exclusive owned by another node writes Busy-shared (3) with owner = sender and empty sharers. It emits a speculative reply (kind 4) to the sender, then an intervention-shared (kind 6) on the request channel (out_chan 1) to the old owner, with out_aux = sender.
- R5: A read-exclusive or upgrade (2) in Shared writes Exclusive with owner = sender. The first record is a reply to the sender: kind 2 for read-exclusive, kind 3 for upgrade. Its out_cnt equals the number of sharers other than the sender. When that number is nonzero, an invalidation (kind 8, request channel) follows, with out_vec = those sharers, destination and aux = sender, and the same count.
- R6: A read-exclusive in Exclusive owned by another node writes Busy-exclusive (4) with owner = sender. It emits a speculative reply, then an intervention-exclusive (kind 7) to the old owner.
- R7: A read, read-exclusive or upgrade that finds Busy-shared or Busy-exclusive, and an upgrade in Unowned or Exclusive, gets one NAK (kind 5) to the sender. The entry is written back unchanged.
- R8: A writeback (3) in Exclusive owned by the sender writes Unowned and acks with kind 9. In Busy-shared it writes Shared, with only the recorded owner as sharer and owner field 0. In Busy-exclusive it writes Exclusive and keeps the owner. In both busy cases the sender first gets a busy ack (kind 10). The recorded owner then gets a bounced response on the reply channel (kind 11 for shared, 12 for exclusive), with aux = sender.
- R9: A sharing writeback (4) or sharing transfer (5) in Busy-shared writes Shared, with sharers = recorded owner and sender, and owner 0. A dirty transfer (6) in Busy-exclusive writes Exclusive and keeps the owner. Neither emits a message.
- R10: When reqnet_ok is 0 at acceptance, the intervention or invalidation record is replaced by a backoff on the reply channel, addressed to the sender. Kind 13 carries the intervended node in out_aux. Kind 14 carries the sharer list and count. The entry update is the same as when reqnet_ok is 1.
- R11: A read, read-exclusive, upgrade or writeback to a Poisoned line (5) returns one bus error (kind 15) to the sender and leaves the entry unchanged.
- R12: Every other combination raises perr for one cycle and produces no entry write and no message. This covers state codes 6 and 7, message code 7, a writeback in the wrong state or from a non-owner, and a transfer in the wrong state.
- R13: A presented record holds its fields stable while out_ready is low. in_ready stays low while any record is pending. The record to the sender is always presented first.
- R14: wr_valid pulses exactly one cycle after each accepted message that is not a protocol error, and carries the new entry in that cycle. The first record is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Controller can accept a message |
| in_kind | input | 3 | Incoming message code |
| in_src | input | NODE_W | Sending node |
| cur_state | input | 3 | Current directory state code |
| cur_owner | input | NODE_W | Current owner field |
| cur_sharers | input | NODES | Current sharer vector |
| reqnet_ok | input | 1 | Request network can take a new message |
| wr_valid | output | 1 | Entry write strobe |
| wr_state | output | 3 | New state code |
| wr_owner | output | NODE_W | New owner field |
| wr_sharers | output | NODES | New sharer vector |
| perr | output | 1 | Protocol-error pulse |
| out_valid | output | 1 | Outgoing record present |
| out_ready | input | 1 | Consumer takes the record |
| out_chan | output | 1 | 0 = reply channel, 1 = request channel |
| out_kind | output | 4 | Outgoing message code |
| out_dest | output | NODE_W | Destination node |
| out_aux | output | NODE_W | Secondary node (requestor or intervened node) |
| out_vec | output | NODES | Sharer list for invalidations |
| out_cnt | output | CNT_W | Expected invalidate acknowledgments |

## Verification
The bench runs a four-node configuration over every combination of state code, message code, sender, recorded owner, sharer vector and request-network readiness, including the illegal codes. Sender-equals-owner against sender-differs-from-owner separates the plain exclusive grant from the busy-and-intervene path. Sharer vectors with and without the sender's bit, and with no other sharer at all, expose mistakes in the acknowledgment count and in suppressing an empty invalidation. Toggling reqnet_ok tells the request-channel path apart from the backoff path, and periodic stalls of out_ready check that a record holds and that input is blocked.

// File: rtl/dir_pkg.sv
// Shared encodings for the home directory controller.
// Assumes: state codes fit 3 bits, message codes 3 bits, outgoing codes 4 bits.
package dir_pkg;

    typedef enum logic [2:0] {
        D_UNOWN  = 3'd0,
        D_SHARED = 3'd1,
        D_EXCL   = 3'd2,
        D_BSHR   = 3'd3,
        D_BEXC   = 3'd4,
        D_POISON = 3'd5
    } dir_state_e;

    typedef enum logic [2:0] {
        Q_READ   = 3'd0,
        Q_RDEX   = 3'd1,
        Q_UPGR   = 3'd2,
        Q_WBACK  = 3'd3,
        Q_SHWB   = 3'd4,
        Q_SHXFER = 3'd5,
        Q_DXFER  = 3'd6
    } in_kind_e;

    typedef enum logic [3:0] {
        M_EXCL        = 4'd0,
        M_SHRD        = 4'd1,
        M_EXCL_INV    = 4'd2,
        M_UPG_ACK     = 4'd3,
        M_SPEC        = 4'd4,
        M_NAK         = 4'd5,
        M_INTV_S      = 4'd6,
        M_INTV_X      = 4'd7,
        M_INVAL       = 4'd8,
        M_WB_EXCL_ACK = 4'd9,
        M_WB_BUSY_ACK = 4'd10,
        M_RESP_S      = 4'd11,
        M_RESP_X      = 4'd12,
        M_BKO_INTV    = 4'd13,
        M_BKO_INVAL   = 4'd14,
        M_BUS_ERR     = 4'd15
    } out_kind_e;

    localparam int NUM_SLOTS = 2;

endpackage

// File: rtl/dir_decide.sv
// Combinational coherence decision for one message against one entry.
// Produces the next entry and up to two outgoing records; slot 0 always
// addresses the sender, slot 1 carries the intervention, invalidation,
// backoff or bounced response. Assumes the caller registers the result.
module dir_decide
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int NODE_W = $clog2(NODES),
    parameter int CNT_W  = $clog2(NODES + 1)
) (
    input  logic [2:0]                       kind,
    input  logic [NODE_W-1:0]                src,
    input  logic [2:0]                       st,
    input  logic [NODE_W-1:0]                own,
    input  logic [NODES-1:0]                 shr,
    input  logic                             net_ok,
    output logic                             err,
    output logic [2:0]                       n_st,
    output logic [NODE_W-1:0]                n_own,
    output logic [NODES-1:0]                 n_shr,
    output logic [NUM_SLOTS-1:0]             m_v,
    output logic [NUM_SLOTS-1:0]             m_chan,
    output logic [NUM_SLOTS-1:0][3:0]        m_kind,
    output logic [NUM_SLOTS-1:0][NODE_W-1:0] m_dest,
    output logic [NUM_SLOTS-1:0][NODE_W-1:0] m_aux,
    output logic [NUM_SLOTS-1:0][NODES-1:0]  m_vec,
    output logic [NUM_SLOTS-1:0][CNT_W-1:0]  m_cnt
);

    logic [NODES-1:0] src_bit;
    logic [NODES-1:0] own_bit;
    logic [NODES-1:0] others;
    logic [CNT_W-1:0] ocnt;
    logic             st_ok;
    logic             self_own;

    // One-hot decode of sender and recorded owner.
    always_comb begin
        for (int i = 0; i < NODES; i++) begin
            src_bit[i] = (src == NODE_W'(i));
            own_bit[i] = (own == NODE_W'(i));
        end
    end

    // Sharers other than the sender and their population count.
    always_comb begin
        others = shr & ~src_bit;
        ocnt   = '0;
        for (int i = 0; i < NODES; i++) begin
            ocnt = ocnt + CNT_W'(others[i]);
        end
    end

    assign st_ok    = (st <= 3'd5);
    assign self_own = (own == src);

    // Main state/message decision.
    always_comb begin
        err    = 1'b0;
        n_st   = st;
        n_own  = own;
        n_shr  = shr;
        m_v    = '0;
        m_chan = '0;
        m_kind = '0;
        m_dest = '0;
        m_aux  = '0;
        m_vec  = '0;
        m_cnt  = '0;
        if (!st_ok || kind == 3'd7) begin
            err = 1'b1;
        end else if (st == D_POISON && kind <= Q_WBACK) begin
            m_v[0]    = 1'b1;
            m_kind[0] = M_BUS_ERR;
            m_dest[0] = src;
        end else begin
            case (kind)
                Q_READ, Q_RDEX: begin
                    if (st == D_BSHR || st == D_BEXC) begin
                        m_v[0]    = 1'b1;
                        m_kind[0] = M_NAK;
                        m_dest[0] = src;
                    end else if (st == D_UNOWN || (st == D_EXCL && self_own)) begin
                        n_st      = D_EXCL;
                        n_own     = src;
                        n_shr     = '0;
                        m_v[0]    = 1'b1;
                        m_kind[0] = M_EXCL;
                        m_dest[0] = src;
                    end else if (st == D_EXCL) begin
                        n_st      = (kind == Q_READ) ? D_BSHR : D_BEXC;
                        n_own     = src;
                        n_shr     = '0;
                        m_v[0]    = 1'b1;
                        m_kind[0] = M_SPEC;
                        m_dest[0] = src;
                        m_v[1]    = 1'b1;
                        if (net_ok) begin
                            m_chan[1] = 1'b1;
                            m_kind[1] = (kind == Q_READ) ? M_INTV_S : M_INTV_X;
                            m_dest[1] = own;
                            m_aux[1]  = src;
                        end else begin
                            m_kind[1] = M_BKO_INTV;
                            m_dest[1] = src;
                            m_aux[1]  = own;
                        end
                    end else if (kind == Q_READ) begin
                        n_shr     = shr | src_bit;
                        m_v[0]    = 1'b1;
                        m_kind[0] = M_SHRD;
                        m_dest[0] = src;
                    end else begin
                        n_st      = D_EXCL;
                        n_own     = src;
                        n_shr     = '0;
                        m_v[0]    = 1'b1;
                        m_kind[0] = M_EXCL_INV;
                        m_dest[0] = src;
                        m_cnt[0]  = ocnt;
                        if (ocnt != '0) begin
                            m_v[1]    = 1'b1;
                            m_chan[1] = net_ok;
                            m_kind[1] = net_ok ? M_INVAL : M_BKO_INVAL;
                            m_dest[1] = src;
                            m_aux[1]  = src;
                            m_vec[1]  = others;
                            m_cnt[1]  = ocnt;
                        end
                    end
                end
                Q_UPGR: begin
                    m_v[0]    = 1'b1;
                    m_dest[0] = src;
                    if (st == D_SHARED) begin
                        n_st      = D_EXCL;
                        n_own     = src;
                        n_shr     = '0;
                        m_kind[0] = M_UPG_ACK;
                        m_cnt[0]  = ocnt;
                        if (ocnt != '0) begin
                            m_v[1]    = 1'b1;
                            m_chan[1] = net_ok;
                            m_kind[1] = net_ok ? M_INVAL : M_BKO_INVAL;
                            m_dest[1] = src;
                            m_aux[1]  = src;
                            m_vec[1]  = others;
                            m_cnt[1]  = ocnt;
                        end
                    end else begin
                        m_kind[0] = M_NAK;
                    end
                end
                Q_WBACK: begin
                    if (st == D_EXCL && self_own) begin
                        n_st      = D_UNOWN;
                        n_own     = '0;
                        n_shr     = '0;
                        m_v[0]    = 1'b1;
                        m_kind[0] = M_WB_EXCL_ACK;
                        m_dest[0] = src;
                    end else if (st == D_BSHR || st == D_BEXC) begin
                        n_st      = (st == D_BSHR) ? D_SHARED : D_EXCL;
                        n_own     = (st == D_BSHR) ? '0 : own;
                        n_shr     = (st == D_BSHR) ? own_bit : '0;
                        m_v[0]    = 1'b1;
                        m_kind[0] = M_WB_BUSY_ACK;
                        m_dest[0] = src;
                        m_v[1]    = 1'b1;
                        m_kind[1] = (st == D_BSHR) ? M_RESP_S : M_RESP_X;
                        m_dest[1] = own;
                        m_aux[1]  = src;
                    end else begin
                        err = 1'b1;
                    end
                end
                Q_SHWB, Q_SHXFER: begin
                    if (st == D_BSHR) begin
                        n_st  = D_SHARED;
                        n_own = '0;
                        n_shr = own_bit | src_bit;
                    end else begin
                        err = 1'b1;
                    end
                end
                Q_DXFER: begin
                    if (st == D_BEXC) begin
                        n_st  = D_EXCL;
                        n_shr = '0;
                    end else begin
                        err = 1'b1;
                    end
                end
                default: err = 1'b1;
            endcase
        end
        if (err) begin
            n_st  = st;
            n_own = own;
            n_shr = shr;
            m_v   = '0;
        end
    end

endmodule

// File: rtl/dir_outq.sv
// Two-slot outgoing record sequencer with valid/ready handshake.
// Loads both slots in one cycle and drains slot 0 before slot 1.
// Assumes load is only asserted while pend is low.
module dir_outq
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int NODE_W = $clog2(NODES),
    parameter int CNT_W  = $clog2(NODES + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [NUM_SLOTS-1:0]             ld_v,
    input  logic [NUM_SLOTS-1:0]             ld_chan,
    input  logic [NUM_SLOTS-1:0][3:0]        ld_kind,
    input  logic [NUM_SLOTS-1:0][NODE_W-1:0] ld_dest,
    input  logic [NUM_SLOTS-1:0][NODE_W-1:0] ld_aux,
    input  logic [NUM_SLOTS-1:0][NODES-1:0]  ld_vec,
    input  logic [NUM_SLOTS-1:0][CNT_W-1:0]  ld_cnt,
    output logic                             pend,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic                             out_chan,
    output logic [3:0]                       out_kind,
    output logic [NODE_W-1:0]                out_dest,
    output logic [NODE_W-1:0]                out_aux,
    output logic [NODES-1:0]                 out_vec,
    output logic [CNT_W-1:0]                 out_cnt
);

    logic [NUM_SLOTS-1:0]             sv;
    logic [NUM_SLOTS-1:0]             schan;
    logic [NUM_SLOTS-1:0][3:0]        skind;
    logic [NUM_SLOTS-1:0][NODE_W-1:0] sdest;
    logic [NUM_SLOTS-1:0][NODE_W-1:0] saux;
    logic [NUM_SLOTS-1:0][NODES-1:0]  svec;
    logic [NUM_SLOTS-1:0][CNT_W-1:0]  scnt;
    logic                             sel;
    logic                             take;

    assign sel  = !sv[0];
    assign take = out_valid && out_ready;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Slot valid: set on load, cleared when this slot is taken.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sv[g] <= 1'b0;
            end else if (load) begin
                sv[g] <= ld_v[g];
            end else if (take && (sel == 1'(g))) begin
                sv[g] <= 1'b0;
            end
        end

        // Slot payload: captured on load, held otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                schan[g] <= 1'b0;
                skind[g] <= '0;
                sdest[g] <= '0;
                saux[g]  <= '0;
                svec[g]  <= '0;
                scnt[g]  <= '0;
            end else if (load) begin
                schan[g] <= ld_chan[g];
                skind[g] <= ld_kind[g];
                sdest[g] <= ld_dest[g];
                saux[g]  <= ld_aux[g];
                svec[g]  <= ld_vec[g];
                scnt[g]  <= ld_cnt[g];
            end
        end
    end

    // Present the oldest valid slot.
    always_comb begin
        pend      = |sv;
        out_valid = |sv;
        out_chan  = schan[sel];
        out_kind  = skind[sel];
        out_dest  = sdest[sel];
        out_aux   = saux[sel];
        out_vec   = svec[sel];
        out_cnt   = scnt[sel];
    end

endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node directory controller: accepts one coherence message at a time,
// writes back the new entry one cycle later and emits its outgoing records
// through a two-slot sequencer. Assumes the entry inputs are valid with
// in_valid and that the caller applies wr_* in the strobe cycle.
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int NODE_W = $clog2(NODES),
    parameter int CNT_W  = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_kind,
    input  logic [NODE_W-1:0] in_src,
    input  logic [2:0]        cur_state,
    input  logic [NODE_W-1:0] cur_owner,
    input  logic [NODES-1:0]  cur_sharers,
    input  logic              reqnet_ok,
    output logic              wr_valid,
    output logic [2:0]        wr_state,
    output logic [NODE_W-1:0] wr_owner,
    output logic [NODES-1:0]  wr_sharers,
    output logic              perr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_chan,
    output logic [3:0]        out_kind,
    output logic [NODE_W-1:0] out_dest,
    output logic [NODE_W-1:0] out_aux,
    output logic [NODES-1:0]  out_vec,
    output logic [CNT_W-1:0]  out_cnt
);

    logic                             d_err;
    logic [2:0]                       d_st;
    logic [NODE_W-1:0]                d_own;
    logic [NODES-1:0]                 d_shr;
    logic [NUM_SLOTS-1:0]             d_v;
    logic [NUM_SLOTS-1:0]             d_chan;
    logic [NUM_SLOTS-1:0][3:0]        d_kind;
    logic [NUM_SLOTS-1:0][NODE_W-1:0] d_dest;
    logic [NUM_SLOTS-1:0][NODE_W-1:0] d_aux;
    logic [NUM_SLOTS-1:0][NODES-1:0]  d_vec;
    logic [NUM_SLOTS-1:0][CNT_W-1:0]  d_cnt;
    logic                             pend;
    logic                             accept;

    assign in_ready = !pend;
    assign accept   = in_valid && in_ready;

    dir_decide #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_dec (
        .kind   (in_kind),
        .src    (in_src),
        .st     (cur_state),
        .own    (cur_owner),
        .shr    (cur_sharers),
        .net_ok (reqnet_ok),
        .err    (d_err),
        .n_st   (d_st),
        .n_own  (d_own),
        .n_shr  (d_shr),
        .m_v    (d_v),
        .m_chan (d_chan),
        .m_kind (d_kind),
        .m_dest (d_dest),
        .m_aux  (d_aux),
        .m_vec  (d_vec),
        .m_cnt  (d_cnt)
    );

    // Entry write strobe, new entry and protocol-error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid   <= 1'b0;
            wr_state   <= '0;
            wr_owner   <= '0;
            wr_sharers <= '0;
            perr       <= 1'b0;
        end else begin
            wr_valid <= accept && !d_err;
            perr     <= accept && d_err;
            if (accept) begin
                wr_state   <= d_st;
                wr_owner   <= d_own;
                wr_sharers <= d_shr;
            end
        end
    end

    dir_outq #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .ld_v      (d_v),
        .ld_chan   (d_chan),
        .ld_kind   (d_kind),
        .ld_dest   (d_dest),
        .ld_aux    (d_aux),
        .ld_vec    (d_vec),
        .ld_cnt    (d_cnt),
        .pend      (pend),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_chan  (out_chan),
        .out_kind  (out_kind),
        .out_dest  (out_dest),
        .out_aux   (out_aux),
        .out_vec   (out_vec),
        .out_cnt   (out_cnt)
    );

endmodule

// File: rtl/dir_home_chk.sv
// Protocol checker bound to dir_home_ctrl. Observes ports only.
module dir_home_chk
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int NODE_W = $clog2(NODES),
    parameter int CNT_W  = $clog2(NODES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        in_kind,
    input logic [2:0]        cur_state,
    input logic              wr_valid,
    input logic [2:0]        wr_state,
    input logic [NODES-1:0]  wr_sharers,
    input logic              perr,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_chan,
    input logic [3:0]        out_kind,
    input logic [NODE_W-1:0] out_dest,
    input logic [CNT_W-1:0]  out_cnt
);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dest) && $stable(out_cnt)); // R13

    AST_BLOCK_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R13

    AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(in_valid && in_ready)); // R14

    AST_PERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        perr |-> !wr_valid && !out_valid); // R12

    AST_NAK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && out_valid && out_kind == M_NAK |-> wr_state == $past(cur_state)); // R7

    AST_REQ_CHAN_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_chan |-> (out_kind == M_INTV_S || out_kind == M_INTV_X || out_kind == M_INVAL)); // R10

    AST_SHARED_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_state == D_SHARED |-> wr_sharers != '0); // R3

    AST_DXFER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && $past(in_kind) == Q_DXFER |-> wr_state == D_EXCL); // R9

endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_dir_home_ctrl.sv
// Exhaustive sweep of the directory controller in a four-node configuration.
module sim_dir_home_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 4;
    localparam int NODE_W = 2;
    localparam int CNT_W  = 3;
    localparam int WATCHDOG_CYCLES = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [2:0]        in_kind = '0;
    logic [NODE_W-1:0] in_src = '0;
    logic [2:0]        cur_state = '0;
    logic [NODE_W-1:0] cur_owner = '0;
    logic [NODES-1:0]  cur_sharers = '0;
    logic              reqnet_ok = 1'b1;
    logic              wr_valid;
    logic [2:0]        wr_state;
    logic [NODE_W-1:0] wr_owner;
    logic [NODES-1:0]  wr_sharers;
    logic              perr;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic              out_chan;
    logic [3:0]        out_kind;
    logic [NODE_W-1:0] out_dest;
    logic [NODE_W-1:0] out_aux;
    logic [NODES-1:0]  out_vec;
    logic [CNT_W-1:0]  out_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // Expected results from the requirement model.
    bit          e_err;
    int          e_st, e_own, e_n;
    logic [3:0]  e_shr;
    int          e_chan[2], e_kind[2], e_dest[2], e_aux[2], e_vec[2], e_cnt[2];
    string       tag;
    // Observed records.
    int          g_n;
    int          g_chan[3], g_kind[3], g_dest[3], g_aux[3], g_vec[3], g_cnt[3];

    dir_home_ctrl #(.NODES(NODES)) u0 (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: counts cycles, a timeout is a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG_CYCLES && !done) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic put(input int i, input int ch, input int k, input int d,
                       input int a, input int v, input int c);
        e_chan[i] = ch; e_kind[i] = k; e_dest[i] = d;
        e_aux[i] = a; e_vec[i] = v; e_cnt[i] = c;
        e_n = i + 1;
    endtask

    // Requirement model of one message.
    task automatic model(input int st, input int k, input int s, input int o,
                         input logic [3:0] sh, input bit net);
        logic [3:0] sbit, obit, oth;
        int oc;
        sbit = 4'b0001 << s;
        obit = 4'b0001 << o;
        oth  = sh & ~sbit;
        oc   = $countones(oth);
        e_err = 1'b0; e_st = st; e_own = o; e_shr = sh; e_n = 0;
        for (int i = 0; i < 2; i++) begin
            e_chan[i] = 0; e_kind[i] = 0; e_dest[i] = 0;
            e_aux[i] = 0; e_vec[i] = 0; e_cnt[i] = 0;
        end
        tag = "R12";
        if (st > 5 || k == 7) begin
            e_err = 1'b1;
        end else if (st == 5 && k <= 3) begin
            tag = "R11"; put(0, 0, 15, s, 0, 0, 0);
        end else if (k <= 1) begin
            if (st == 3 || st == 4) begin
                tag = "R7"; put(0, 0, 5, s, 0, 0, 0);
            end else if (st == 0 || (st == 2 && o == s)) begin
                tag = "R2"; e_st = 2; e_own = s; e_shr = 0; put(0, 0, 0, s, 0, 0, 0);
            end else if (st == 2) begin
                tag = (k == 0) ? "R4" : "R6";
                e_st = (k == 0) ? 3 : 4; e_own = s; e_shr = 0;
                put(0, 0, 4, s, 0, 0, 0);
                if (net) put(1, 1, (k == 0) ? 6 : 7, o, s, 0, 0);
                else begin tag = "R10"; put(1, 0, 13, s, o, 0, 0); end
            end else if (k == 0) begin
                tag = "R3"; e_shr = sh | sbit; put(0, 0, 1, s, 0, 0, 0);
            end else begin
                tag = "R5"; e_st = 2; e_own = s; e_shr = 0;
                put(0, 0, 2, s, 0, 0, oc);
                if (oc > 0) begin
                    if (net) put(1, 1, 8, s, s, int'(oth), oc);
                    else begin tag = "R10"; put(1, 0, 14, s, s, int'(oth), oc); end
                end
            end
        end else if (k == 2) begin
            if (st == 1) begin
                tag = "R5"; e_st = 2; e_own = s; e_shr = 0;
                put(0, 0, 3, s, 0, 0, oc);
                if (oc > 0) begin
                    if (net) put(1, 1, 8, s, s, int'(oth), oc);
                    else begin tag = "R10"; put(1, 0, 14, s, s, int'(oth), oc); end
                end
            end else begin
                tag = "R7"; put(0, 0, 5, s, 0, 0, 0);
            end
        end else if (k == 3) begin
            tag = "R8";
            if (st == 2 && o == s) begin
                e_st = 0; e_own = 0; e_shr = 0; put(0, 0, 9, s, 0, 0, 0);
            end else if (st == 3) begin
                e_st = 1; e_own = 0; e_shr = obit;
                put(0, 0, 10, s, 0, 0, 0); put(1, 0, 11, o, s, 0, 0);
            end else if (st == 4) begin
                e_st = 2; e_shr = 0;
                put(0, 0, 10, s, 0, 0, 0); put(1, 0, 12, o, s, 0, 0);
            end else begin
                tag = "R12"; e_err = 1'b1;
            end
        end else if (k == 4 || k == 5) begin
            if (st == 3) begin tag = "R9"; e_st = 1; e_own = 0; e_shr = obit | sbit; end
            else e_err = 1'b1;
        end else begin
            if (st == 4) begin tag = "R9"; e_st = 2; e_shr = 0; end
            else e_err = 1'b1;
        end
    endtask

    task automatic fail_line(input string what, input int act, input int exp);
        $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    endtask

    // Apply one vector, gather its results and compare.
    task automatic run_vec(input int st, input int k, input int s, input int o,
                           input int sh, input bit net, input bit stall);
        bit bad;
        int k0;
        model(st, k, s, o, sh[3:0], net);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k[2:0]; in_src = s[1:0];
        cur_state = st[2:0]; cur_owner = o[1:0]; cur_sharers = sh[3:0];
        reqnet_ok = net;
        @(negedge clk);
        in_valid = 1'b0;
        bad = 1'b0;
        // R14: strobe and entry one cycle after acceptance.
        if (wr_valid !== !e_err) begin bad = 1'b1; fail_line("R14 wr_valid", int'(wr_valid), int'(!e_err)); end
        if (perr !== e_err) begin bad = 1'b1; fail_line("perr", int'(perr), int'(e_err)); end
        if (!e_err) begin
            if (int'(wr_state) != e_st) begin bad = 1'b1; fail_line("wr_state", int'(wr_state), e_st); end
            if (int'(wr_owner) != e_own) begin bad = 1'b1; fail_line("wr_owner", int'(wr_owner), e_own); end
            if (wr_sharers !== e_shr) begin bad = 1'b1; fail_line("wr_sharers", int'(wr_sharers), int'(e_shr)); end
        end
        if (stall && out_valid) begin
            // R13: record holds and input is blocked while stalled.
            out_ready = 1'b0;
            k0 = int'(out_kind);
            @(negedge clk);
            n_checks = n_checks + 1;
            if (!out_valid || int'(out_kind) != k0 || in_ready) begin
                n_fails = n_fails + 1;
                $display("FAIL R13 stall hold: actual valid=%0d kind=%0d ready=%0d expected 1/%0d/0",
                         out_valid, out_kind, in_ready, k0);
            end
            out_ready = 1'b1;
        end
        g_n = 0;
        for (int i = 0; i < 3; i++) begin
            if (out_valid) begin
                g_chan[g_n] = int'(out_chan); g_kind[g_n] = int'(out_kind);
                g_dest[g_n] = int'(out_dest); g_aux[g_n] = int'(out_aux);
                g_vec[g_n] = int'(out_vec); g_cnt[g_n] = int'(out_cnt);
                g_n = g_n + 1;
            end
            @(negedge clk);
        end
        if (g_n != e_n) begin bad = 1'b1; fail_line("record count", g_n, e_n); end
        else begin
            for (int i = 0; i < e_n; i++) begin
                if (g_kind[i] != e_kind[i]) begin bad = 1'b1; fail_line("kind", g_kind[i], e_kind[i]); end
                if (g_chan[i] != e_chan[i]) begin bad = 1'b1; fail_line("chan", g_chan[i], e_chan[i]); end
                if (g_dest[i] != e_dest[i]) begin bad = 1'b1; fail_line("dest", g_dest[i], e_dest[i]); end
                if (g_aux[i] != e_aux[i]) begin bad = 1'b1; fail_line("aux", g_aux[i], e_aux[i]); end
                if (g_vec[i] != e_vec[i]) begin bad = 1'b1; fail_line("vec", g_vec[i], e_vec[i]); end
                if (g_cnt[i] != e_cnt[i]) begin bad = 1'b1; fail_line("cnt", g_cnt[i], e_cnt[i]); end
            end
        end
        if (in_ready !== 1'b1) begin bad = 1'b1; fail_line("R13 in_ready after drain", int'(in_ready), 1); end
        n_checks = n_checks + 1;
        if (bad) begin
            n_fails = n_fails + 1;
            $display("FAIL %s vector st=%0d kind=%0d src=%0d own=%0d shr=%0d net=%0d",
                     tag, st, k, s, o, sh, net);
        end
    endtask

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset.
        n_checks = n_checks + 1;
        if (in_ready !== 1'b1 || out_valid !== 1'b0 || wr_valid !== 1'b0 || perr !== 1'b0) begin
            n_fails = n_fails + 1;
            $display("FAIL R1 reset: actual ready=%0d valid=%0d wr=%0d perr=%0d expected 1/0/0/0",
                     in_ready, out_valid, wr_valid, perr);
        end
        idx = 0;
        for (int st = 0; st < 8; st++)
            for (int k = 0; k < 8; k++)
                for (int s = 0; s < NODES; s++)
                    for (int o = 0; o < NODES; o++)
                        for (int sh = 0; sh < 16; sh++)
                            for (int net = 0; net < 2; net++) begin
                                run_vec(st, k, s, o, sh, net[0], (idx % 7) == 3);
                                idx = idx + 1;
                            end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule